// File: doc/BRIEF.md
# Page Map Control Sequencer

This block carries out the control commands of an address-translation pager whose map RAM holds 1024 entries. The lower 512 entries (address bit 9 clear) translate monitor pages and the upper 512 (address bit 9 set) translate user pages. A 3-bit command code chooses the operation. The block can revoke access over a range of monitor or user entries, fill the whole map with an identity translation, move the lowest swappable monitor page, raise an illegal-I/O trap, or switch context by clearing both halves and then reloading the base registers from a packed 44-bit word.

Each command that touches the map writes one entry per clock through a plain write port, in ascending address order. The block holds five registers that the rest of the pager reads. The swap floor sets where monitor clearing starts. The user page limit sets how far user clearing goes. The other three are the user table base, the monitor table base and the accumulator-block base. A command is taken only while the block is idle; a request made while it is busy is dropped.

Top module: `pgr_ctl`

## Requirements
- R1: After reset `busy`, `map_we` and `trap_illio` are low, `plo` = 0, `alr` = 512, `ubr` = 0, `mbr` = 0 and `acbase` = 775000 (octal).
- R2: A command is taken on a rising edge where `cmd_valid` is high and `busy` is low. Its map writes start in the following cycle, one entry per cycle at addresses that step up by one. `busy` is high in exactly the cycles that carry a write.
- R3: Code 1 writes the no-access pattern 700000 (octal) to monitor addresses `plo` through 511, in order.
- R4: Code 3 writes 700000 (octal) to user addresses 512 through 512 + `alr` - 1, using the limit held when the command is taken.
- R5: Code 0 clears monitor addresses `plo`..511 and then user addresses 512..512+`alr`-1 (old limit) with no gap. The new base registers appear in the cycle after the last write.
- R6: The base word counts bit 0 as its MSB, and word bit k is port index 43-k. The user limit code is bits 4-6, `ubr` is bits 7-21, the accumulator field is bits 22-26 and `mbr` is bits 31-43.
- R7: A limit code v of 1 to 7 loads `alr` = ((v XOR 7) + 1) shifted left by 5. v = 0 loads 512.
- R8: The accumulator field f loads `acbase` = 775000 + 20·f (octal).
- R9: Codes 4 and 5 write every address 0..1023 with data whose low 9 bits equal the low 9 address bits and whose access field [17:15] is 0. From the next cycle, `plo` = 0 and `alr` = 512.
- R10: Code 6 sets `plo` to 64 and clears monitor addresses 64..511. Code 7 sets `plo` to 0 and clears monitor addresses 0..511.
- R11: Code 2 pulses `trap_illio` for the one cycle after it is taken, with no map write and no register change.
- R12: A `cmd_valid` raised while `busy` is high has no effect on writes or registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 3 | Command selector |
| cmd_word | input | 44 | Packed base word, used by code 0 |
| busy | output | 1 | A map sequence is running |
| trap_illio | output | 1 | Illegal-I/O trap pulse |
| map_we | output | 1 | Map RAM write enable |
| map_addr | output | 10 | Map RAM address (bit 9 = user half) |
| map_wdata | output | 18 | Map RAM write data |
| plo | output | 9 | Lowest swappable monitor page |
| alr | output | 10 | First illegal user page |
| ubr | output | 15 | User table base |
| mbr | output | 13 | Monitor table base |
| acbase | output | 18 | Accumulator block base |

## Verification
Monitor clears run from both floors, 0 and 64. This tells a wrong starting point apart from a wrong end point. User clears run after limits of 512, 160 and 32 have been loaded through switch commands, so the limit decode and the range end are both tested. The switch command is run with limit codes 3, 7, 1 and 0 and with different field values. This separates a field that is taken from the wrong bit position from a wrong limit formula, and shows that the user clear uses the old limit. Identity fills, the trap code and a request made while busy complete the set. They show whether the data pattern, the register side effects and the busy gating are right.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  localparam int WORD_W = 44;
  localparam int UBR_W  = 15;
  localparam int MBR_W  = 13;
  localparam int ACB_W  = 18;
  localparam int LIMF_W = 3;
  localparam int ACBF_W = 5;
  // lsb index of each field; word bit k (0 = msb) sits at index WORD_W-1-k
  localparam int LIMF_LSB = WORD_W - 1 - 6;
  localparam int UBR_LSB  = WORD_W - 1 - 21;
  localparam int ACBF_LSB = WORD_W - 1 - 26;
  localparam int MBR_LSB  = WORD_W - 1 - 43;
  localparam logic [ACB_W-1:0] ACB_ORIGIN = 18'o775000;

  typedef enum logic [1:0] {PH_IDLE, PH_MON, PH_USR, PH_IDN} phase_e;

  typedef enum logic [2:0] {
    OP_SWITCH  = 3'd0,
    OP_DROPMON = 3'd1,
    OP_BADIO   = 3'd2,
    OP_DROPUSR = 3'd3,
    OP_IDENT_A = 3'd4,
    OP_IDENT_B = 3'd5,
    OP_FLOOR64 = 3'd6,
    OP_FLOOR0  = 3'd7
  } op_e;
endpackage

// File: rtl/pgr_base_unpack.sv
module pgr_base_unpack
  import pgr_pkg::*;
#(
  parameter int PAGE_W = 9
) (
  input  logic [WORD_W-1:0]  word,
  output logic [PAGE_W:0]    lim,
  output logic [UBR_W-1:0]   ubr_f,
  output logic [MBR_W-1:0]   mbr_f,
  output logic [ACB_W-1:0]   acb_f
);
  localparam int LIM_W = PAGE_W + 1;

  logic [LIMF_W-1:0] code;
  logic [ACBF_W-1:0] acf;
  logic [3:0]        steps;

  always_comb begin
    code  = word[LIMF_LSB +: LIMF_W];
    acf   = word[ACBF_LSB +: ACBF_W];
    ubr_f = word[UBR_LSB +: UBR_W];
    mbr_f = word[MBR_LSB +: MBR_W];
    steps = {1'b0, ~code} + 4'd1;
    if (code == '0) lim = LIM_W'(1) << PAGE_W;
    else            lim = LIM_W'(steps) << 5;
    acb_f = ACB_ORIGIN + (ACB_W'(acf) << 4);
  end
endmodule

// File: rtl/pgr_seq.sv
module pgr_seq
  import pgr_pkg::*;
#(
  parameter int PAGE_W  = 9,
  parameter int ENTRY_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_mon,
  input  logic               go_usr,
  input  logic               go_idn,
  input  logic [PAGE_W-1:0]  mon_lo,
  input  logic [PAGE_W:0]    usr_cnt,
  output logic               busy,
  output logic               fin,
  output logic [PAGE_W:0]    wr_addr,
  output logic [ENTRY_W-1:0] wr_data
);
  localparam int ADDR_W = PAGE_W + 1;
  localparam logic [ENTRY_W-1:0] NOACC = {3'b111, {(ENTRY_W-3){1'b0}}};

  phase_e              ph_q, ph_d;
  logic [ADDR_W-1:0]   ptr_q, ptr_d, last_q, last_d;
  logic                chain_q, chain_d;
  logic [PAGE_W-1:0]   ulast_q, ulast_d;
  logic [PAGE_W-1:0]   usr_top;
  logic                usr_ok, at_end, more;

  assign usr_ok  = (usr_cnt != '0);
  assign usr_top = PAGE_W'(usr_cnt - 1'b1);
  assign at_end  = (ptr_q == last_q);
  assign more    = (ph_q == PH_MON) && chain_q;

  always_comb begin
    ph_d    = ph_q;
    ptr_d   = ptr_q;
    last_d  = last_q;
    chain_d = chain_q;
    ulast_d = ulast_q;
    if (ph_q == PH_IDLE) begin
      if (go_mon) begin
        ph_d    = PH_MON;
        ptr_d   = {1'b0, mon_lo};
        last_d  = {1'b0, {PAGE_W{1'b1}}};
        chain_d = go_usr && usr_ok;
        ulast_d = usr_top;
      end else if (go_usr && usr_ok) begin
        ph_d   = PH_USR;
        ptr_d  = {1'b1, {PAGE_W{1'b0}}};
        last_d = {1'b1, usr_top};
      end else if (go_idn) begin
        ph_d   = PH_IDN;
        ptr_d  = '0;
        last_d = '1;
      end
    end else if (at_end) begin
      chain_d = 1'b0;
      if (more) begin
        ph_d   = PH_USR;
        ptr_d  = {1'b1, {PAGE_W{1'b0}}};
        last_d = {1'b1, ulast_q};
      end else begin
        ph_d = PH_IDLE;
      end
    end else begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      ptr_q   <= '0;
      last_q  <= '0;
      chain_q <= 1'b0;
      ulast_q <= '0;
    end else begin
      ph_q    <= ph_d;
      ptr_q   <= ptr_d;
      last_q  <= last_d;
      chain_q <= chain_d;
      ulast_q <= ulast_d;
    end
  end

  assign busy    = (ph_q != PH_IDLE);
  assign fin     = busy && at_end && !more;
  assign wr_addr = ptr_q;
  assign wr_data = (ph_q == PH_IDN)
                 ? {{(ENTRY_W-PAGE_W){1'b0}}, ptr_q[PAGE_W-1:0]}
                 : NOACC;
endmodule

// File: rtl/pgr_ctl.sv
module pgr_ctl
  import pgr_pkg::*;
#(
  parameter int PAGE_W   = 9,
  parameter int ENTRY_W  = 18,
  parameter int FLOOR_HI = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_code,
  input  logic [WORD_W-1:0]  cmd_word,
  output logic               busy,
  output logic               trap_illio,
  output logic               map_we,
  output logic [PAGE_W:0]    map_addr,
  output logic [ENTRY_W-1:0] map_wdata,
  output logic [PAGE_W-1:0]  plo,
  output logic [PAGE_W:0]    alr,
  output logic [UBR_W-1:0]   ubr,
  output logic [MBR_W-1:0]   mbr,
  output logic [ACB_W-1:0]   acbase
);
  localparam int LIM_W = PAGE_W + 1;
  localparam logic [LIM_W-1:0] LIM_FULL = LIM_W'(1) << PAGE_W;

  logic              accept, fin, seq_busy;
  logic              go_mon, go_usr, go_idn;
  logic [PAGE_W-1:0] mon_lo;

  logic [PAGE_W-1:0] plo_q, plo_d;
  logic [LIM_W-1:0]  alr_q, alr_d;
  logic [UBR_W-1:0]  ubr_q, ubr_d;
  logic [MBR_W-1:0]  mbr_q, mbr_d;
  logic [ACB_W-1:0]  acb_q, acb_d;
  logic              trap_q, trap_d, reload_q, reload_d, reg_en;

  logic [LIM_W-1:0]  n_lim, p_lim, p_lim_d;
  logic [UBR_W-1:0]  n_ubr, p_ubr, p_ubr_d;
  logic [MBR_W-1:0]  n_mbr, p_mbr, p_mbr_d;
  logic [ACB_W-1:0]  n_acb, p_acb, p_acb_d;

  pgr_base_unpack #(.PAGE_W(PAGE_W)) u_unpack (
    .word(cmd_word), .lim(n_lim), .ubr_f(n_ubr), .mbr_f(n_mbr), .acb_f(n_acb)
  );

  pgr_seq #(.PAGE_W(PAGE_W), .ENTRY_W(ENTRY_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go_mon(go_mon), .go_usr(go_usr), .go_idn(go_idn),
    .mon_lo(mon_lo), .usr_cnt(alr_q),
    .busy(seq_busy), .fin(fin),
    .wr_addr(map_addr), .wr_data(map_wdata)
  );

  assign accept = cmd_valid && !seq_busy;
  assign reg_en = accept || fin;

  always_comb begin
    go_mon   = 1'b0;
    go_usr   = 1'b0;
    go_idn   = 1'b0;
    mon_lo   = plo_q;
    trap_d   = 1'b0;
    plo_d    = plo_q;
    alr_d    = alr_q;
    ubr_d    = ubr_q;
    mbr_d    = mbr_q;
    acb_d    = acb_q;
    reload_d = reload_q;
    p_lim_d  = p_lim;
    p_ubr_d  = p_ubr;
    p_mbr_d  = p_mbr;
    p_acb_d  = p_acb;
    if (fin && reload_q) begin
      alr_d    = p_lim;
      ubr_d    = p_ubr;
      mbr_d    = p_mbr;
      acb_d    = p_acb;
      reload_d = 1'b0;
    end
    if (accept) begin
      unique case (op_e'(cmd_code))
        OP_SWITCH: begin
          go_mon   = 1'b1;
          go_usr   = 1'b1;
          reload_d = 1'b1;
          p_lim_d  = n_lim;
          p_ubr_d  = n_ubr;
          p_mbr_d  = n_mbr;
          p_acb_d  = n_acb;
        end
        OP_DROPMON: go_mon = 1'b1;
        OP_BADIO:   trap_d = 1'b1;
        OP_DROPUSR: go_usr = 1'b1;
        OP_IDENT_A, OP_IDENT_B: begin
          go_idn = 1'b1;
          plo_d  = '0;
          alr_d  = LIM_FULL;
        end
        OP_FLOOR64: begin
          go_mon = 1'b1;
          mon_lo = PAGE_W'(FLOOR_HI);
          plo_d  = PAGE_W'(FLOOR_HI);
        end
        OP_FLOOR0: begin
          go_mon = 1'b1;
          mon_lo = '0;
          plo_d  = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q   <= 1'b0;
      plo_q    <= '0;
      alr_q    <= LIM_FULL;
      ubr_q    <= '0;
      mbr_q    <= '0;
      acb_q    <= ACB_ORIGIN;
      reload_q <= 1'b0;
      p_lim    <= '0;
      p_ubr    <= '0;
      p_mbr    <= '0;
      p_acb    <= '0;
    end else begin
      trap_q <= trap_d;
      if (reg_en) begin
        plo_q    <= plo_d;
        alr_q    <= alr_d;
        ubr_q    <= ubr_d;
        mbr_q    <= mbr_d;
        acb_q    <= acb_d;
        reload_q <= reload_d;
        p_lim    <= p_lim_d;
        p_ubr    <= p_ubr_d;
        p_mbr    <= p_mbr_d;
        p_acb    <= p_acb_d;
      end
    end
  end

  assign busy       = seq_busy;
  assign map_we     = seq_busy;
  assign trap_illio = trap_q;
  assign plo        = plo_q;
  assign alr        = alr_q;
  assign ubr        = ubr_q;
  assign mbr        = mbr_q;
  assign acbase     = acb_q;
endmodule

// File: rtl/pgr_ctl_chk.sv
module pgr_ctl_chk #(
  parameter int PAGE_W  = 9,
  parameter int ENTRY_W = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [2:0]         cmd_code,
  input logic               busy,
  input logic               trap_illio,
  input logic               map_we,
  input logic [PAGE_W:0]    map_addr,
  input logic [ENTRY_W-1:0] map_wdata,
  input logic [PAGE_W-1:0]  plo,
  input logic [PAGE_W:0]    alr
);
  localparam logic [ENTRY_W-1:0] NOACC = {3'b111, {(ENTRY_W-3){1'b0}}};

  // R2
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> busy);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we && $past(map_we)) |-> (map_addr == $past(map_addr) + 1'b1));

  // R3
  clear_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we && map_wdata[ENTRY_W-1 -: 3] != 3'b000) |-> (map_wdata == NOACC));

  // R9
  ident_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we && map_wdata[ENTRY_W-1 -: 3] == 3'b000)
      |-> (map_wdata[PAGE_W-1:0] == map_addr[PAGE_W-1:0]));

  // R12
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(plo));

  // R11
  trap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_illio |-> $past(cmd_valid && cmd_code == 3'd2 && !busy));

  // R7
  limit_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alr[4:0] == 5'd0) && (alr <= ((PAGE_W+1)'(1) << PAGE_W)));
endmodule

bind pgr_ctl pgr_ctl_chk #(.PAGE_W(PAGE_W), .ENTRY_W(ENTRY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .busy(busy), .trap_illio(trap_illio), .map_we(map_we),
  .map_addr(map_addr), .map_wdata(map_wdata), .plo(plo), .alr(alr)
);

// File: tb/pgr_ctl_tb.sv
module pgr_ctl_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {int addr; int data; string tag;} wr_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_code;
  logic [43:0] cmd_word;
  logic        busy, trap_illio, map_we;
  logic [9:0]  map_addr;
  logic [17:0] map_wdata;
  logic [8:0]  plo;
  logic [9:0]  alr;
  logic [14:0] ubr;
  logic [12:0] mbr;
  logic [17:0] acbase;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  wr_t q[$];
  int m_plo, m_alr, m_ubr, m_mbr, m_acb;
  int p_alr, p_ubr, p_mbr, p_acb;
  bit m_reload, exp_trap;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgr_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_word(cmd_word), .busy(busy), .trap_illio(trap_illio),
    .map_we(map_we), .map_addr(map_addr), .map_wdata(map_wdata),
    .plo(plo), .alr(alr), .ubr(ubr), .mbr(mbr), .acbase(acbase)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fld(logic [43:0] w, int a, int b);
    int v = 0;
    for (int k = a; k <= b; k++) v = v * 2 + int'(w[43-k]);
    return v;
  endfunction

  function automatic logic [43:0] mkword(int lv, int u, int f, int m);
    logic [43:0] w = '0;
    int t;
    t = lv; for (int k = 6;  k >= 4;  k--) begin w[43-k] = t[0]; t = t >> 1; end
    t = u;  for (int k = 21; k >= 7;  k--) begin w[43-k] = t[0]; t = t >> 1; end
    t = f;  for (int k = 26; k >= 22; k--) begin w[43-k] = t[0]; t = t >> 1; end
    t = m;  for (int k = 43; k >= 31; k--) begin w[43-k] = t[0]; t = t >> 1; end
    return w;
  endfunction

  task automatic push_range(int lo, int hi, string tag);
    for (int a = lo; a <= hi; a++) q.push_back('{a, 'o700000, tag});
  endtask

  task automatic model_accept(int code, logic [43:0] w);
    int v;
    case (code)
      0: begin
        push_range(m_plo, 511, "R5");
        push_range(512, 512 + m_alr - 1, "R5");
        m_reload = 1;
        v = fld(w, 4, 6);
        p_alr = (v == 0) ? 512 : (8 - v) * 32;
        p_ubr = fld(w, 7, 21);
        p_acb = 'o775000 + 'o20 * fld(w, 22, 26);
        p_mbr = fld(w, 31, 43);
      end
      1: push_range(m_plo, 511, "R3");
      2: exp_trap = 1;
      3: push_range(512, 512 + m_alr - 1, "R4");
      4, 5: begin
        for (int a = 0; a < 1024; a++) q.push_back('{a, a % 512, "R9"});
        m_plo = 0;
        m_alr = 512;
      end
      6: begin m_plo = 64; push_range(64, 511, "R10"); end
      default: begin m_plo = 0; push_range(0, 511, "R10"); end
    endcase
  endtask

  task automatic compare();
    bit eb = (q.size() != 0);
    chk(busy == eb, "R2 busy", int'(busy), int'(eb));
    if (eb)
      chk(map_we && int'(map_addr) == q[0].addr && int'(map_wdata) == q[0].data,
          q[0].tag, int'(map_addr) * 1000000 + int'(map_wdata),
          q[0].addr * 1000000 + q[0].data);
    else
      chk(!map_we, "R2 idle write", int'(map_we), 0);
    chk(trap_illio == exp_trap, "R11", int'(trap_illio), int'(exp_trap));
    chk(int'(plo) == m_plo, "R10 plo", int'(plo), m_plo);
    chk(int'(alr) == m_alr, "R7 alr", int'(alr), m_alr);
    chk(int'(ubr) == m_ubr, "R6 ubr", int'(ubr), m_ubr);
    chk(int'(mbr) == m_mbr, "R6 mbr", int'(mbr), m_mbr);
    chk(int'(acbase) == m_acb, "R8 acbase", int'(acbase), m_acb);
  endtask

  task automatic step();
    bit was_busy;
    @(posedge clk);
    #1;
    was_busy = (q.size() != 0);
    exp_trap = 0;
    if (was_busy) begin
      void'(q.pop_front());
      if (q.size() == 0 && m_reload) begin
        m_reload = 0;
        m_alr = p_alr; m_ubr = p_ubr; m_mbr = p_mbr; m_acb = p_acb;
      end
    end
    if (cmd_valid && !was_busy) model_accept(int'(cmd_code), cmd_word);
    @(negedge clk);
    compare();
  endtask

  task automatic issue(int code, logic [43:0] w);
    cmd_valid = 1'b1;
    cmd_code  = 3'(code);
    cmd_word  = w;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) step();
    step();
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; cmd_word = '0;
    m_plo = 0; m_alr = 512; m_ubr = 0; m_mbr = 0; m_acb = 'o775000;
    m_reload = 0; exp_trap = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !map_we && !trap_illio, "R1 flags", int'({busy, map_we, trap_illio}), 0);
    chk(plo == 0 && alr == 512, "R1 plo/alr", int'(alr), 512);
    chk(ubr == 0 && mbr == 0 && acbase == 18'o775000, "R1 bases", int'(acbase), 'o775000);
    rst_n = 1'b1;
    step();
    issue(1, '0); drain();                              // R3 from floor 0
    issue(6, '0); drain();                              // R10 floor 64
    issue(1, '0);                                       // R3 from floor 64
    cmd_valid = 1'b1; cmd_code = 3'd7;                  // R12 request while busy
    step(); step();
    cmd_valid = 1'b0;
    chk(int'(plo) == 64, "R12 plo kept", int'(plo), 64);
    drain();
    issue(3, '0); drain();                              // R4 limit 512
    issue(0, mkword(3, 'h1234, 5, 'h0abc)); drain();    // R5 R6 R7 R8
    issue(3, '0); drain();                              // R4 limit 160
    issue(2, '0); drain();                              // R11
    issue(0, mkword(7, 'h7fff, 31, 'h1fff)); drain();   // R7 code 7
    issue(3, '0); drain();                              // R4 limit 32
    issue(4, '0); drain();                              // R9
    issue(6, '0); drain();
    issue(0, mkword(1, 'h0001, 1, 'h1000)); drain();    // R7 code 1
    issue(5, '0); drain();                              // R9 code 5
    issue(7, '0); drain();                              // R10 code 7
    issue(0, mkword(0, 'h4000, 16, 'h0001)); drain();   // R7 code 0
    issue(3, '0); drain();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule